// File: doc/BRIEF.md
# Dual Decade/Binary Up Counter

This block contains two 4-bit up counters, channel A and channel B. They share nothing except the system clock and the global reset. A build parameter sets both channels to decade counting (0 to 9) or to full binary counting (0 to 15). Each channel has three control pins: a count-clock pin, a count-enable pin and a level clear. It also drives its current code and a one-cycle wrap strobe.

The two count pins of a channel are interchangeable. The count advances on a rising edge of the clock pin while the enable pin is high, or on a falling edge of the enable pin while the clock pin is low. This lets a designer chain stages either way:

- Ripple style: the previous stage's top bit feeds the enable pin.
- Synchronous style: a common clock feeds every stage and the previous stage's wrap feeds the enable pin.

The count pins are not clocks. They are sampled as data on the system clock, passed through a synchronizer and edge-detected there. All bits of a code are updated in the same system clock cycle.

In decade mode, an out-of-range code returns to zero within two count events.

Top module: `dcnt_dual`

## Requirements
- R1: The two channels are independent: count, clear or edge activity on one channel never changes the other channel's code or wrap strobe.
- R2: A low-to-high change on a channel's clock pin, while that channel's enable pin was high in the previous sample, adds one to the code. The new code appears on the third rising system clock edge after the pin change, counting the first sampling edge as the first.
- R3: A high-to-low change on a channel's enable pin, while that channel's clock pin was low in the previous sample, adds one to the code. The latency is the same as in R2.
- R4: A clock-pin rise and an enable-pin fall seen in the same sample add exactly one. No other pin change counts, including:
  - a rise of the enable pin;
  - a fall of the clock pin;
  - a clock rise while the enable pin was low;
  - an enable fall while the clock pin was high.
- R5: While a channel's clear pin is high, its code is 0 from the next system clock edge onward, and count edges seen during that time are discarded.
- R6: A high level on the global reset drives both codes to 0 and both wrap strobes to 0 at the next edge.
- R7: In decade mode (parameter DECADE = 1), the code steps 0, 1, …, 9 and then back to 0. No out-of-range code is ever entered from an in-range code.
- R8: In binary mode (DECADE = 0), the code steps 0, 1, …, 15 and then back to 0.
- R9: In decade mode, a count event moves an out-of-range code as follows, so every such code reaches 0 within two events:
  - 10 → 11, 12 → 13, 14 → 15;
  - 11, 13 and 15 → 0.
- R10: The wrap strobe is high for exactly one system clock cycle, in the cycle in which the code has just gone from 9 to 0 (decade mode) or from 15 to 0 (binary mode). It stays low when an out-of-range code falls to 0.
- R11: The code changes by at most one step per system clock cycle. It only ever moves to its successor or to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock; all state changes on its rising edge |
| sys_rst | input | 1 | Synchronous active-high global reset |
| a_clk | input | 1 | Channel A count-clock pin (rising edge counts) |
| a_en | input | 1 | Channel A count-enable pin (falling edge counts) |
| a_clr | input | 1 | Channel A level clear, active high |
| a_q | output | 4 | Channel A current code |
| a_carry | output | 1 | Channel A one-cycle wrap strobe |
| b_clk | input | 1 | Channel B count-clock pin (rising edge counts) |
| b_en | input | 1 | Channel B count-enable pin (falling edge counts) |
| b_clr | input | 1 | Channel B level clear, active high |
| b_q | output | 4 | Channel B current code |
| b_carry | output | 1 | Channel B one-cycle wrap strobe |

## Verification
The hardest condition to reach is a decade counter holding a code from 10 to 15. Reset and clear both force zero, and legal counting never leaves the 0 to 9 range, so no pin sequence leads there. The bench holds the global reset and, meanwhile, forces the channel's stored code to each out-of-range value. It lets the reset go while the force is still in effect, then releases the force. From then on it drives only ordinary count edges, and checks the code and the wrap strobe at the ports after each edge. A second hard case is a clock-pin rise and an enable-pin fall in the same sample. The bench reaches it by changing both pins in one drive step, so they cross the synchronizer together.

// File: rtl/dcnt_pkg.sv
`timescale 1ns/1ps
package dcnt_pkg;

    localparam int CODE_W = 4;
    localparam int NCH    = 2;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic {
        RADIX_BIN = 1'b0,
        RADIX_DEC = 1'b1
    } radix_e;

    // current and previous synchronized samples of one channel's pins
    typedef struct packed {
        logic clk_cur;
        logic clk_prv;
        logic en_cur;
        logic en_prv;
    } pin_hist_t;

    typedef struct packed {
        code_t code;
        logic  carry;
    } step_t;

    // qualified count event: clock rise with enable previously high,
    // or enable fall with clock previously low; both together give one event
    function automatic logic count_event(pin_hist_t h);
        logic rise_ok;
        logic fall_ok;
        rise_ok = h.clk_cur & ~h.clk_prv & h.en_prv;
        fall_ok = ~h.en_cur & h.en_prv & ~h.clk_prv;
        return rise_ok | fall_ok;
    endfunction

    // successor code and wrap flag for one count event
    function automatic step_t advance(radix_e r, code_t c);
        step_t s;
        s.carry = 1'b0;
        if (r == RADIX_BIN) begin
            s.code  = c + code_t'(1);
            s.carry = (c == code_t'(15));
        end else if (c < code_t'(9)) begin
            s.code = c + code_t'(1);
        end else if (c == code_t'(9)) begin
            s.code  = '0;
            s.carry = 1'b1;
        end else if (c[0] == 1'b0) begin
            s.code = c + code_t'(1);
        end else begin
            s.code = '0;
        end
        return s;
    endfunction

endpackage

// File: rtl/dcnt_sync.sv
`timescale 1ns/1ps
module dcnt_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prv   <= '0;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
            prv <= chain[LAST];
        end
    end

    assign cur = chain[LAST];

endmodule

// File: rtl/dcnt_trig.sv
`timescale 1ns/1ps
module dcnt_trig
    import dcnt_pkg::*;
(
    input  pin_hist_t hist,
    output logic      bump
);
    assign bump = count_event(hist);
endmodule

// File: rtl/dcnt_stage.sv
`timescale 1ns/1ps
module dcnt_stage
    import dcnt_pkg::*;
#(
    parameter radix_e RADIX = RADIX_DEC
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  bump,
    output code_t q,
    output logic  carry
);
    code_t cnt_q;
    logic  carry_q;
    step_t nxt;

    assign nxt = advance(RADIX, cnt_q);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q   <= '0;
            carry_q <= 1'b0;
        end else if (bump) begin
            cnt_q   <= nxt.code;
            carry_q <= nxt.carry;
        end else begin
            carry_q <= 1'b0;
        end
    end

    assign q     = cnt_q;
    assign carry = carry_q;

endmodule

// File: rtl/dcnt_dual.sv
`timescale 1ns/1ps
module dcnt_dual
    import dcnt_pkg::*;
#(
    parameter bit DECADE      = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic       sys_clk,
    input  logic       sys_rst,
    input  logic       a_clk,
    input  logic       a_en,
    input  logic       a_clr,
    output logic [3:0] a_q,
    output logic       a_carry,
    input  logic       b_clk,
    input  logic       b_en,
    input  logic       b_clr,
    output logic [3:0] b_q,
    output logic       b_carry
);
    localparam radix_e RADIX_SEL = DECADE ? RADIX_DEC : RADIX_BIN;

    logic [NCH-1:0]             pin_clk;
    logic [NCH-1:0]             pin_en;
    logic [NCH-1:0]             pin_clr;
    logic [NCH-1:0]             ch_bump;
    logic [NCH-1:0]             carry_arr;
    logic [NCH-1:0][CODE_W-1:0] q_arr;

    assign pin_clk = {b_clk, a_clk};
    assign pin_en  = {b_en,  a_en};
    assign pin_clr = {b_clr, a_clr};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [1:0] cur;
        logic [1:0] prv;
        pin_hist_t  hist;

        dcnt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
            .clk (sys_clk),
            .rst (sys_rst),
            .din ({pin_clk[ch], pin_en[ch]}),
            .cur (cur),
            .prv (prv)
        );

        assign hist.clk_cur = cur[1];
        assign hist.clk_prv = prv[1];
        assign hist.en_cur  = cur[0];
        assign hist.en_prv  = prv[0];

        dcnt_trig u_trig (
            .hist (hist),
            .bump (ch_bump[ch])
        );

        dcnt_stage #(.RADIX(RADIX_SEL)) u_cnt (
            .clk   (sys_clk),
            .rst   (sys_rst),
            .clr   (pin_clr[ch]),
            .bump  (ch_bump[ch]),
            .q     (q_arr[ch]),
            .carry (carry_arr[ch])
        );
    end

    assign a_q     = q_arr[0];
    assign b_q     = q_arr[1];
    assign a_carry = carry_arr[0];
    assign b_carry = carry_arr[1];

endmodule

// File: rtl/dcnt_dual_chk.sv
`timescale 1ns/1ps
module dcnt_dual_chk
    import dcnt_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input logic                       sys_clk,
    input logic                       sys_rst,
    input logic [NCH-1:0]             clr,
    input logic [NCH-1:0]             bump,
    input logic [NCH-1:0]             carry,
    input logic [NCH-1:0][CODE_W-1:0] q
);
    localparam code_t TOP = DECADE ? code_t'(9) : code_t'(15);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        AST_CLR_HOLDS_ZERO: assert property (@(posedge sys_clk) disable iff (sys_rst)
            clr[ch] |=> (q[ch] == '0)); // R5

        AST_SINGLE_STEP: assert property (@(posedge sys_clk) disable iff (sys_rst)
            !$stable(q[ch]) |-> (q[ch] == '0 || q[ch] == code_t'($past(q[ch]) + code_t'(1)))); // R11

        AST_QUIET_WITHOUT_EVENT: assert property (@(posedge sys_clk) disable iff (sys_rst)
            (!$past(bump[ch]) && !$past(clr[ch])) |-> $stable(q[ch])); // R2

        AST_CARRY_AT_WRAP: assert property (@(posedge sys_clk) disable iff (sys_rst)
            carry[ch] |-> (q[ch] == '0 && $past(q[ch]) == TOP)); // R10

        AST_CARRY_SINGLE: assert property (@(posedge sys_clk) disable iff (sys_rst)
            carry[ch] |=> !carry[ch]); // R10

        if (DECADE) begin : g_dec
            AST_NO_ILLEGAL_ENTRY: assert property (@(posedge sys_clk) disable iff (sys_rst)
                (q[ch] > code_t'(9)) |-> ($past(q[ch]) > code_t'(9))); // R7
        end
    end

endmodule

bind dcnt_dual dcnt_dual_chk #(.DECADE(DECADE)) u_chk (
    .sys_clk (sys_clk),
    .sys_rst (sys_rst),
    .clr     (pin_clr),
    .bump    (ch_bump),
    .carry   (carry_arr),
    .q       (q_arr)
);

// File: tb/dcnt_dual_test.sv
`timescale 1ns/1ps
module dcnt_dual_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_clk = 0, a_en = 0, a_clr = 0;
    logic b_clk = 0, b_en = 0, b_clr = 0;
    logic [3:0] a_q, b_q, ba_q, bb_q;
    logic a_carry, b_carry, ba_carry, bb_carry;

    int n_chk = 0;
    int n_bad = 0;
    int car_a = 0, car_b = 0, car_ba = 0;
    bit finished = 0;

    always #4ns clk = ~clk;

    dcnt_dual #(.DECADE(1'b1)) uut (
        .sys_clk(clk), .sys_rst(rst),
        .a_clk(a_clk), .a_en(a_en), .a_clr(a_clr), .a_q(a_q), .a_carry(a_carry),
        .b_clk(b_clk), .b_en(b_en), .b_clr(b_clr), .b_q(b_q), .b_carry(b_carry)
    );

    dcnt_dual #(.DECADE(1'b0)) uut_bin (
        .sys_clk(clk), .sys_rst(rst),
        .a_clk(a_clk), .a_en(a_en), .a_clr(a_clr), .a_q(ba_q), .a_carry(ba_carry),
        .b_clk(b_clk), .b_en(b_en), .b_clr(b_clr), .b_q(bb_q), .b_carry(bb_carry)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (a_carry)  car_a++;
            if (b_carry)  car_b++;
            if (ba_carry) car_ba++;
        end
    end

    // bits: a_clk a_en a_clr a_expect | b_clk b_en b_clr b_expect
    localparam int NVEC = 15;
    localparam logic [7:0] VEC [NVEC] = '{
        8'b0100_0100, 8'b1101_0001, 8'b0100_0100, 8'b1101_0001,
        8'b0000_1000, 8'b1000_0100, 8'b0100_0001, 8'b1001_1100,
        8'b0000_0000, 8'b0110_1000, 8'b1111_0100, 8'b0100_0001,
        8'b0100_0110, 8'b1101_0011, 8'b0100_0100
    };

    function automatic int dec_next(int c);
        case (c)
            9, 11, 13, 15: return 0;
            default:       return c + 1;
        endcase
    endfunction

    function automatic int bin_next(int c);
        return (c == 15) ? 0 : c + 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_a_clk();
        a_clk = 1'b1; settle();
        a_clk = 1'b0; settle();
    endtask

    task automatic pulse_b_en();
        b_en = 1'b0; settle();
        b_en = 1'b1; settle();
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        int ma = 0, mb = 0, mba = 0, mbb = 0;
        int c0;
        logic [3:0] fcode;

        repeat (3) @(negedge clk);
        // R6: reset state
        check(a_q == 0 && b_q == 0, "R6 reset codes", a_q + 16 * b_q, 0);
        check(a_carry == 0 && b_carry == 0, "R6 reset strobes", a_carry + b_carry, 0);
        rst = 1'b0;
        settle();

        // table walk: R1 R2 R3 R4 R5 in both radices
        for (int v = 0; v < NVEC; v++) begin
            a_clk = VEC[v][7]; a_en = VEC[v][6]; a_clr = VEC[v][5];
            b_clk = VEC[v][3]; b_en = VEC[v][2]; b_clr = VEC[v][1];
            settle();
            if (VEC[v][5])      begin ma = 0; mba = 0; end
            else if (VEC[v][4]) begin ma = dec_next(ma); mba = bin_next(mba); end
            if (VEC[v][1])      begin mb = 0; mbb = 0; end
            else if (VEC[v][0]) begin mb = dec_next(mb); mbb = bin_next(mbb); end
            check(int'(a_q) == ma, "R1/R2/R4/R5 chan A", a_q, ma);
            check(int'(b_q) == mb, "R1/R3/R4/R5 chan B", b_q, mb);
            check(int'(ba_q) == mba && int'(bb_q) == mbb, "R1/R8 binary pair",
                  ba_q + 16 * bb_q, mba + 16 * mbb);
        end

        // R2 latency: new code on the third edge after the pin change
        a_clr = 1'b1; settle(); a_clr = 1'b0; a_en = 1'b1; a_clk = 1'b0; settle();
        a_clk = 1'b1;
        repeat (2) @(negedge clk);
        check(a_q == 0, "R2 not before third edge", a_q, 0);
        @(negedge clk);
        check(a_q == 1, "R2 on third edge", a_q, 1);
        a_clk = 1'b0; settle();

        // R7 R8 R10: wrap with clock-pin pulses; channel B held still (R1)
        a_clr = 1'b1; settle(); a_clr = 1'b0; settle();
        b_clk = 1'b0; b_en = 1'b1; settle();
        mb = int'(b_q);
        c0 = car_a;
        for (int k = 1; k <= 16; k++) begin
            int ca = car_ba;
            pulse_a_clk();
            check(int'(a_q) == k % 10, "R7 decade step", a_q, k % 10);
            check(int'(ba_q) == k % 16, "R8 binary step", ba_q, k % 16);
            if (k == 9)  check(car_a == c0, "R10 no strobe before wrap", car_a - c0, 0);
            if (k == 10) check(car_a == c0 + 1, "R10 decade wrap strobe", car_a - c0, 1);
            if (k == 16) check(car_ba == ca + 1, "R10 binary wrap strobe", car_ba - ca, 1);
        end
        check(int'(b_q) == mb && car_b == 0, "R1 B untouched", b_q, mb);

        // R3 R7 R10: ten enable-pin falls on B; A must stay (R1)
        b_clr = 1'b1; settle(); b_clr = 1'b0; settle();
        c0 = car_b;
        ma = int'(a_q);
        for (int k = 1; k <= 10; k++) pulse_b_en();
        check(b_q == 0 && car_b == c0 + 1, "R3/R10 B decade wrap", car_b - c0, 1);
        check(int'(a_q) == ma, "R1 A untouched", a_q, ma);

        // R5: clear held across several count edges
        a_clr = 1'b1;
        for (int k = 0; k < 3; k++) begin
            pulse_a_clk();
            check(a_q == 0, "R5 clear held", a_q, 0);
        end
        a_clr = 1'b0; settle();
        pulse_a_clk();
        check(a_q == 1, "R5 count after clear", a_q, 1);

        // R6: global reset mid-count
        pulse_a_clk();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(a_q == 0 && b_q == 0 && ba_q == 0, "R6 reset mid-count", a_q + ba_q, 0);
        rst = 1'b0; settle();

        // R9 R10: out-of-range decade codes
        a_clk = 1'b0; a_en = 1'b1;
        for (int c = 10; c <= 15; c++) begin
            int e1;
            fcode = 4'(c);
            rst = 1'b1;
            @(negedge clk);
            force uut.g_ch[0].u_cnt.cnt_q = fcode;
            @(negedge clk);
            rst = 1'b0;
            @(negedge clk);
            release uut.g_ch[0].u_cnt.cnt_q;
            settle();
            check(int'(a_q) == c, "R9 preload held", a_q, c);
            c0 = car_a;
            e1 = dec_next(c);
            pulse_a_clk();
            check(int'(a_q) == e1, "R9 first event", a_q, e1);
            if (e1 != 0) begin
                pulse_a_clk();
                check(a_q == 0, "R9 second event", a_q, 0);
            end
            check(car_a == c0, "R10 no strobe on recovery", car_a - c0, 0);
        end

        report();
    end

endmodule